// File: doc/BRIEF.md
# Launch Authorization Key-Hash Register Gate

This block keeps a 256-bit public-key hash that decides which signers may launch protected software, and it screens initialization requests against that hash. Software reaches the hash through four 64-bit registers on a simple register port. Whether a hash write is accepted depends on three things: the one-way activation state, a lock bit and a hash-write-enable bit, both held in a feature-control register.

A separate initialize-request port takes two candidate signer hashes, one from the image and one from its launch token. One cycle later the port reports whether either candidate equals the stored hash. A capability word tells software whether the feature is built in. Before activation, a protected-range configuration register can also be written. Activation then freezes it.

Top module: `lakey_gate`

## Requirements
- R1: After reset, registers 0..3 read back the built-in default hash, with lane 0 holding bits 63:0 of the 256-bit value. The feature-control register reads 0, and the block is not activated.
- R2: Bit 30 of `cap_word` is 1 when the feature is built in, and all other bits are 0. Without the feature, `cap_word` is 0 and any access to registers 0..3 returns data 0 with `reg_err` set.
- R3: A read issued in one cycle presents its data on `reg_rdata` in the next cycle, with `reg_err` low for a mapped address. Register addresses are: 0..3 hash lanes, 4 feature control, 5 range configuration.
- R4: Before activation, while feature control is unlocked, a hash-lane write takes effect and raises no error.
- R5: After activation, a hash-lane write takes effect only when feature control is locked (bit 0) with the hash-write-enable bit (bit 17) set. Any other hash-lane write leaves the lane unchanged and pulses `reg_err` in the cycle after the write.
- R6: Once feature control is locked with bit 17 clear, every hash-lane write is refused with `reg_err`, even before activation, until reset.
- R7: Feature control at address 4 loads bit 0 (lock) and bit 17 (hash-write enable) only while unlocked. A write after locking is ignored and pulses `reg_err`.
- R8: The range configuration at address 5 accepts writes only before activation. Afterwards a write leaves it unchanged and pulses `reg_err`.
- R9: A one-cycle pulse on `activate` sets the activation state. The state stays set until reset, and reset clears it.
- R10: One cycle after `init_req`, `init_done` pulses. `init_pass` is 1 exactly when `signer_img` or `signer_tok` equals the stored 256-bit hash in every bit.
- R11: A read of an unmapped address (6 or 7) returns 0 and pulses `reg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe (takes priority over read) |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after a read |
| reg_err | output | 1 | Pulse: access refused or unmapped, the cycle after the access |
| activate | input | 1 | One-way activation pulse |
| cap_word | output | 32 | Capability word, bit 30 = feature built in |
| init_req | input | 1 | Initialize-request strobe |
| signer_img | input | 256 | Signer hash carried by the image |
| signer_tok | input | 256 | Signer hash carried by the launch token |
| init_done | output | 1 | Pulse: authorization result valid |
| init_pass | output | 1 | Authorization granted |

## Verification
A wrong permission state inside the block shows at the ports in the cycle right after the next hash or range write. If the state is wrong, either `reg_err` rises where it should not, or a following read returns a changed or unchanged lane against expectation. Because of this, every write in the tests is followed by a read-back. A stuck activation or lock bit stays hidden until a write probes it, so the directed tests probe repeatedly: after activation, many cycles later, and across a reset. A corrupted stored hash appears on the very next authorization result. For that reason the authorization tests include a candidate that differs in a single lane.

// File: rtl/lakey_pkg.sv
package lakey_pkg;
  localparam int unsigned LANE_W   = 64;
  localparam int unsigned LANES    = 4;
  localparam int unsigned HASH_W   = LANE_W * LANES;
  localparam int unsigned LIDX_W   = $clog2(LANES);
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned CAP_W    = 32;
  localparam int unsigned CAP_BIT  = 30;
  localparam int unsigned LOCK_BIT = 0;
  localparam int unsigned WREN_BIT = 17;
  localparam logic [ADDR_W-1:0] A_FCTL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_RANGE = 3'd5;
endpackage

// File: rtl/lakey_rst_sync.sv
module lakey_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ni = sync_q[STAGES-1];
endmodule

// File: rtl/lakey_keyhash_regs.sv
module lakey_keyhash_regs
  import lakey_pkg::*;
#(
  parameter logic [HASH_W-1:0] DEFAULT_HASH = '0
) (
  input  logic                            clk,
  input  logic                            rst_ni,
  input  logic                            wr_hash,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [LANE_W-1:0]               wdata,
  output logic [LANES-1:0][LANE_W-1:0]    lane_q
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic              we;
    logic [LANE_W-1:0] lane_d;

    always_comb begin
      we     = wr_hash && (addr == ADDR_W'(i));
      lane_d = we ? wdata : lane_q[i];
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) lane_q[i] <= DEFAULT_HASH[i*LANE_W +: LANE_W];
      else         lane_q[i] <= lane_d;
    end
  end
endmodule

// File: rtl/lakey_featctl.sv
module lakey_featctl
  import lakey_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_fctl,
  input  logic              wr_range,
  input  logic [LANE_W-1:0] wdata,
  input  logic              activate,
  output logic              lock_q,
  output logic              wren_q,
  output logic              active_q,
  output logic [LANE_W-1:0] range_q,
  output logic              fctl_deny,
  output logic              range_deny,
  output logic              hash_wr_ok
);
  logic              lock_d, wren_d, active_d;
  logic [LANE_W-1:0] range_d;

  always_comb begin
    lock_d     = lock_q;
    wren_d     = wren_q;
    range_d    = range_q;
    active_d   = active_q | activate;
    fctl_deny  = wr_fctl & lock_q;
    range_deny = wr_range & active_q;
    if (wr_fctl && !lock_q) begin
      lock_d = wdata[LOCK_BIT];
      wren_d = wdata[WREN_BIT];
    end
    if (wr_range && !active_q) range_d = wdata;
  end

  // locked: only the enable bit decides; unlocked: only pre-activation
  assign hash_wr_ok = lock_q ? wren_q : !active_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q   <= 1'b0;
      wren_q   <= 1'b0;
      active_q <= 1'b0;
      range_q  <= '0;
    end else begin
      lock_q   <= lock_d;
      wren_q   <= wren_d;
      active_q <= active_d;
      range_q  <= range_d;
    end
  end

  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    lock_q |=> (lock_q && $stable(wren_q)));
  assert_active_oneway_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    active_q |=> active_q);
  assert_range_frozen_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    active_q |=> $stable(range_q));
endmodule

// File: rtl/lakey_signer_match.sv
module lakey_signer_match
  import lakey_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_ni,
  input  logic                         req,
  input  logic [LANES-1:0][LANE_W-1:0] lane_q,
  input  logic [HASH_W-1:0]            cand_a,
  input  logic [HASH_W-1:0]            cand_b,
  output logic                         done_q,
  output logic                         pass_q
);
  logic [LANES-1:0] eq_a, eq_b;

  for (genvar i = 0; i < LANES; i++) begin : g_cmp
    assign eq_a[i] = (cand_a[i*LANE_W +: LANE_W] == lane_q[i]);
    assign eq_b[i] = (cand_b[i*LANE_W +: LANE_W] == lane_q[i]);
  end

  logic done_d, pass_d;
  always_comb begin
    done_d = req;
    pass_d = req && ((&eq_a) || (&eq_b));
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      done_q <= done_d;
      pass_q <= pass_d;
    end
  end
endmodule

// File: rtl/lakey_gate.sv
module lakey_gate
  import lakey_pkg::*;
#(
  parameter logic [HASH_W-1:0] DEFAULT_HASH    = {64'hA5A5_0F0F_3C3C_9696, 64'h0123_4567_89AB_CDEF,
                                                  64'hFEDC_BA98_7654_3210, 64'h5A5A_F0F0_C3C3_6969},
  parameter bit                FEATURE_PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [LANE_W-1:0] reg_wdata,
  output logic [LANE_W-1:0] reg_rdata,
  output logic              reg_err,
  input  logic              activate,
  output logic [CAP_W-1:0]  cap_word,
  input  logic              init_req,
  input  logic [HASH_W-1:0] signer_img,
  input  logic [HASH_W-1:0] signer_tok,
  output logic              init_done,
  output logic              init_pass
);
  logic rst_ni;
  lakey_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_ni(rst_ni));

  logic feat_on;
  if (FEATURE_PRESENT) begin : g_feat
    assign feat_on  = 1'b1;
    assign cap_word = CAP_W'(1) << CAP_BIT;
  end else begin : g_nofeat
    assign feat_on  = 1'b0;
    assign cap_word = '0;
  end

  logic is_hash, wr_hash, wr_fctl, wr_range, rd_en;
  always_comb begin
    is_hash  = reg_addr < ADDR_W'(LANES);
    rd_en    = reg_rd && !reg_wr;
    wr_fctl  = reg_wr && (reg_addr == A_FCTL);
    wr_range = reg_wr && (reg_addr == A_RANGE);
  end

  logic lock_q, wren_q, active_q, fctl_deny, range_deny, hash_wr_ok;
  logic [LANE_W-1:0] range_q;

  lakey_featctl u_fctl (
    .clk(clk), .rst_ni(rst_ni), .wr_fctl(wr_fctl), .wr_range(wr_range),
    .wdata(reg_wdata), .activate(activate), .lock_q(lock_q), .wren_q(wren_q),
    .active_q(active_q), .range_q(range_q), .fctl_deny(fctl_deny),
    .range_deny(range_deny), .hash_wr_ok(hash_wr_ok)
  );

  assign wr_hash = reg_wr && is_hash && feat_on && hash_wr_ok;

  logic [LANES-1:0][LANE_W-1:0] lane_q;
  lakey_keyhash_regs #(.DEFAULT_HASH(DEFAULT_HASH)) u_hash (
    .clk(clk), .rst_ni(rst_ni), .wr_hash(wr_hash), .addr(reg_addr),
    .wdata(reg_wdata), .lane_q(lane_q)
  );

  lakey_signer_match u_match (
    .clk(clk), .rst_ni(rst_ni), .req(init_req), .lane_q(lane_q),
    .cand_a(signer_img), .cand_b(signer_tok), .done_q(init_done), .pass_q(init_pass)
  );

  // register port: next state
  logic [LANE_W-1:0] rdata_d, fctl_view;
  logic              err_d;
  always_comb begin
    fctl_view           = '0;
    fctl_view[LOCK_BIT] = lock_q;
    fctl_view[WREN_BIT] = wren_q;
    rdata_d = reg_rdata;
    err_d   = 1'b0;
    if (reg_wr) begin
      if (is_hash)                    err_d = !(feat_on && hash_wr_ok);
      else if (reg_addr == A_FCTL)    err_d = fctl_deny;
      else if (reg_addr == A_RANGE)   err_d = range_deny;
      else                            err_d = 1'b1;
    end else if (rd_en) begin
      rdata_d = '0;
      if (is_hash) begin
        if (feat_on) rdata_d = lane_q[reg_addr[LIDX_W-1:0]];
        else         err_d   = 1'b1;
      end else if (reg_addr == A_FCTL)  rdata_d = fctl_view;
      else if (reg_addr == A_RANGE)     rdata_d = range_q;
      else                              err_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rdata <= '0;
      reg_err   <= 1'b0;
    end else begin
      reg_err <= err_d;
      if (rd_en) reg_rdata <= rdata_d;
    end
  end

  assert_hash_guarded_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (reg_wr && is_hash && !hash_wr_ok) |=> $stable(lane_q));
  assert_locked_noen_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (lock_q && !wren_q) |=> $stable(lane_q));
  assert_err_after_access_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    reg_err |-> $past(reg_wr || reg_rd));
  assert_pass_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    init_pass |-> $past(init_req));
endmodule

// File: tb/sim_lakey_gate.sv
module sim_lakey_gate;
  localparam logic [255:0] DEF = {64'hA5A5_0F0F_3C3C_9696, 64'h0123_4567_89AB_CDEF,
                                  64'hFEDC_BA98_7654_3210, 64'h5A5A_F0F0_C3C3_6969};

  logic clk = 1'b0;
  logic rst_n, reg_wr, reg_rd, activate, init_req;
  logic [2:0] reg_addr;
  logic [63:0] reg_wdata, reg_rdata, rdata1;
  logic reg_err, err1, init_done, init_pass, done1, pass1;
  logic [31:0] cap_word, cap1;
  logic [255:0] signer_img, signer_tok, stored;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  lakey_gate #(.DEFAULT_HASH(DEF), .FEATURE_PRESENT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err), .activate(activate),
    .cap_word(cap_word), .init_req(init_req), .signer_img(signer_img),
    .signer_tok(signer_tok), .init_done(init_done), .init_pass(init_pass));

  lakey_gate #(.DEFAULT_HASH(DEF), .FEATURE_PRESENT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata1), .reg_err(err1), .activate(activate),
    .cap_word(cap1), .init_req(init_req), .signer_img(signer_img),
    .signer_tok(signer_tok), .init_done(done1), .init_pass(pass1));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; activate = 0; init_req = 0;
    reg_addr = '0; reg_wdata = '0; signer_img = '0; signer_tok = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    stored = DEF;
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d, output logic e);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    e = reg_err;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d, output logic e);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata; e = reg_err;
  endtask

  task automatic auth(input logic [255:0] a, input logic [255:0] b, output logic ok);
    @(negedge clk);
    init_req = 1; signer_img = a; signer_tok = b;
    @(negedge clk);
    init_req = 0;
    check("R10 done", 64'(init_done), 64'd1);
    ok = init_pass;
  endtask

  task automatic pulse_activate();
    @(negedge clk); activate = 1;
    @(negedge clk); activate = 0;
  endtask

  task automatic t_reset_state();
    logic [63:0] d; logic e;
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), d, e);
      check("R1 lane default", d, DEF[i*64 +: 64]);
      check("R3 read err", 64'(e), 64'd0);
    end
    rd(3'd4, d, e);
    check("R1 fctl reset", d, 64'd0);
    check("R2 cap", 64'(cap_word), 64'h4000_0000);
  endtask

  task automatic t_no_feature();
    logic [63:0] d; logic e;
    check("R2 cap absent", 64'(cap1), 64'd0);
    rd(3'd1, d, e);
    check("R2 absent read data", rdata1, 64'd0);
    check("R2 absent read err", 64'(err1), 64'd1);
  endtask

  task automatic t_pre_write();
    logic [63:0] d; logic e;
    wr(3'd2, 64'h1111_2222_3333_4444, e);
    check("R4 write err", 64'(e), 64'd0);
    rd(3'd2, d, e);
    check("R4 readback", d, 64'h1111_2222_3333_4444);
    stored[128 +: 64] = 64'h1111_2222_3333_4444;
    wr(3'd5, 64'hCAFE_0000_0000_0042, e);
    check("R8 range pre err", 64'(e), 64'd0);
    rd(3'd5, d, e);
    check("R8 range readback", d, 64'hCAFE_0000_0000_0042);
  endtask

  task automatic t_auth();
    logic ok;
    logic [255:0] bad;
    bad = stored; bad[200] = ~bad[200];
    auth(stored, bad, ok);  check("R10 image match", 64'(ok), 64'd1);
    auth(bad, stored, ok);  check("R10 token match", 64'(ok), 64'd1);
    auth(bad, ~stored, ok); check("R10 no match", 64'(ok), 64'd0);
    auth(DEF, '0, ok);      check("R10 stale default", 64'(ok), 64'd0);
  endtask

  task automatic t_unmapped();
    logic [63:0] d; logic e;
    rd(3'd7, d, e);
    check("R11 data", d, 64'd0);
    check("R11 err", 64'(e), 64'd1);
  endtask

  task automatic t_activated();
    logic [63:0] d; logic e;
    pulse_activate();
    wr(3'd0, 64'hDEAD_BEEF_0000_0001, e);
    check("R5 denied err", 64'(e), 64'd1);
    rd(3'd0, d, e);
    check("R5 unchanged", d, DEF[63:0]);
    repeat (20) @(negedge clk);
    wr(3'd5, 64'h0, e);
    check("R8 range post err", 64'(e), 64'd1);
    rd(3'd5, d, e);
    check("R9 range still frozen", d, 64'hCAFE_0000_0000_0042);
  endtask

  task automatic t_lock_enabled();
    logic [63:0] d; logic e;
    wr(3'd4, 64'h0000_0000_0002_0001, e);
    check("R7 fctl write err", 64'(e), 64'd0);
    wr(3'd0, 64'hDEAD_BEEF_0000_0001, e);
    check("R5 allowed err", 64'(e), 64'd0);
    rd(3'd0, d, e);
    check("R5 allowed readback", d, 64'hDEAD_BEEF_0000_0001);
    wr(3'd4, 64'h0, e);
    check("R7 locked write err", 64'(e), 64'd1);
    rd(3'd4, d, e);
    check("R7 fctl unchanged", d, 64'h0000_0000_0002_0001);
  endtask

  task automatic t_lock_disabled();
    logic [63:0] d; logic e;
    do_reset();
    rd(3'd0, d, e);
    check("R1 reset restores lane", d, DEF[63:0]);
    wr(3'd4, 64'h1, e);
    check("R7 lock write err", 64'(e), 64'd0);
    wr(3'd1, 64'h7777, e);
    check("R6 refused err", 64'(e), 64'd1);
    rd(3'd1, d, e);
    check("R6 unchanged", d, DEF[127:64]);
    wr(3'd5, 64'h55, e);
    check("R9 reset cleared activation", 64'(e), 64'd0);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    do_reset();
    t_reset_state();
    t_no_feature();
    t_pre_write();
    t_auth();
    t_unmapped();
    t_activated();
    t_lock_enabled();
    t_lock_disabled();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule